// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block sits in front of the feedback divider of a fractional-N synthesizer and runs on the phase-detector clock. Each cycle it issues the integer divide value the divider should use for its next count. The value is either the integer part of the programmed ratio or one more than that. Over time the average of these values equals the integer part plus a fraction whose numerator and denominator are both programmable. The denominator is a 12-bit modulus that need not be a power of two, so channel steps such as reference/65 or reference/520 can be set up directly.

The fraction is tracked by a first-order accumulator that wraps modulo the programmed modulus. A new integer part, numerator and modulus are applied together when a load strobe is seen. A 4-bit resync field chosen at load time selects one of two behaviours. With the field nonzero, the accumulator restarts from zero, so a given setting always replays the same divide pattern, whatever was programmed before it. With the field zero, the accumulator residue carries over into the new setting, reduced modulo the new modulus. A load whose numerator is not below its modulus is refused and raises an error flag.

Top module: `fracn_divmod`

## Requirements
- R1: On every cycle without a load, the accumulator adds the numerator. If the sum is at least the modulus, the modulus is subtracted and `div_o` shows integer part + 1 after that clock edge. Otherwise `div_o` shows the integer part. The accumulator always stays below the modulus.
- R2: When `load_i` is high at a clock edge and the load is legal, the new integer part, numerator and modulus all take effect at that edge. The `div_o` value shown after that edge is already the first step computed with the new setting. No mix of old and new fields is ever used.
- R3: A load with `frac_i >= mod_i` is refused. This includes every load with `mod_i = 0`. The previous setting and the accumulator stepping continue unchanged, and `err_o` reads 1 from the next edge. `err_o` stays 1 until a legal load clears it, and it returns to 0 at the edge of that load.
- R4: A legal load with `resync_i` nonzero (any of the 15 nonzero codes) clears the accumulator before the first step. Loading setting A, then setting B, then A again therefore produces an identical divide sequence for both loads of A.
- R5: A legal load with `resync_i = 4'b0000` keeps the accumulator residue. The residue is replaced by its value modulo the new modulus before the first step is taken.
- R6: While the numerator is zero, `div_o` equals the integer part on every cycle, with no dithering.
- R7: After a legal resync load, the sum of the `MOD` consecutive `div_o` values starting with the one shown after the load edge equals INT×MOD + FRAC. For MOD = 65, INT = 138 and FRAC = 30 this sum is 9000, and the pattern repeats every 65 cycles.
- R8: Every modulus from 1 to 4095 is accepted, including values that are not powers of two. With MOD = 4095 and FRAC = 4094, the 4095-cycle window sum equals INT×4095 + 4094.
- R9: While reset is applied, and after it is released, the block holds the setting INT = 0, FRAC = 0, MOD = 1, an accumulator of 0, `div_o = 0` and `err_o = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load strobe for a new setting |
| int_i | input | INT_W (16) | Integer part of the divide ratio |
| frac_i | input | MOD_W (12) | Fractional numerator |
| mod_i | input | MOD_W (12) | Fractional modulus |
| resync_i | input | 4 | Resync control; any nonzero value clears the accumulator on load |
| div_o | output | INT_W+1 (17) | Instantaneous divide value, INT or INT+1 |
| err_o | output | 1 | Set by a refused load, cleared by the next legal load |

## Verification
The block has two pairs of functions that can act in the same cycle. First, a load edge also performs an accumulator step, so a new setting can arrive just as the old residue is about to wrap. Second, a refused load coincides with an ordinary step under the old setting. The bench provokes both with back-to-back loads of small moduli (3, 5, 7), with and without resync, that land on wrapping and non-wrapping cycles. It also sends illegal loads in the middle of a dither pattern. Each cycle's `div_o` and `err_o` are compared against a scoreboard that steps a behavioural accumulator from the requirements. Window sums and the A/B/A replay are judged separately from the recorded output history.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int RESYNC_W = 4;
  typedef logic [RESYNC_W-1:0] resync_t;

  function automatic logic resync_on(input resync_t code);
    return |code;
  endfunction
endpackage

// File: rtl/fdm_rstsync.sv
module fdm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fdm_cfg.sv
module fdm_cfg #(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             load_ok_o,
  output logic [INT_W-1:0] int_q_o,
  output logic [MOD_W-1:0] frac_q_o,
  output logic [MOD_W-1:0] mod_q_o,
  output logic [INT_W-1:0] eff_int_o,
  output logic [MOD_W-1:0] eff_frac_o,
  output logic [MOD_W-1:0] eff_mod_o,
  output logic             err_o
);
  logic             legal;
  logic             cfg_en;
  logic             err_en;
  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q;
  logic [MOD_W-1:0] mod_q;
  logic             err_q;
  logic             err_d;

  // next state
  always_comb begin
    legal  = (frac_i < mod_i);
    cfg_en = load_i && legal;
    err_en = load_i;
    err_d  = !legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      mod_q  <= MOD_W'(1);
    end else if (cfg_en) begin
      int_q  <= int_i;
      frac_q <= frac_i;
      mod_q  <= mod_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign load_ok_o  = cfg_en;
  assign int_q_o    = int_q;
  assign frac_q_o   = frac_q;
  assign mod_q_o    = mod_q;
  assign eff_int_o  = cfg_en ? int_i  : int_q;
  assign eff_frac_o = cfg_en ? frac_i : frac_q;
  assign eff_mod_o  = cfg_en ? mod_i  : mod_q;
  assign err_o      = err_q;

  // R3: refused load leaves the setting untouched and raises the flag
  assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !(frac_i < mod_i)) |=>
      ($stable(int_q) && $stable(frac_q) && $stable(mod_q) && err_q));

  // R3: the stored setting is always a legal fraction
  assert_cfg_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frac_q < mod_q);
endmodule

// File: rtl/fdm_modreduce.sv
module fdm_modreduce #(
  parameter int W = 12
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] r_o
);
  logic [W:0] rem [0:W];

  assign rem[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_stage
    logic [W:0] shifted;
    assign shifted    = {rem[g][W-1:0], x_i[W-1-g]};
    assign rem[g+1]   = (shifted >= {1'b0, m_i}) ? (shifted - {1'b0, m_i}) : shifted;
  end

  assign r_o = rem[W][W-1:0];
endmodule

// File: rtl/fdm_accum.sv
module fdm_accum #(
  parameter int MOD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_ok_i,
  input  fdm_pkg::resync_t     resync_i,
  input  logic [MOD_W-1:0]     eff_frac_i,
  input  logic [MOD_W-1:0]     eff_mod_i,
  input  logic [MOD_W-1:0]     mod_q_i,
  output logic                 carry_o
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] acc_q;
  logic [MOD_W-1:0] acc_d;
  logic [MOD_W-1:0] residue;
  logic [MOD_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic             carry;
  logic             acc_en;

  fdm_modreduce #(.W(MOD_W)) u_reduce (
    .x_i (acc_q),
    .m_i (eff_mod_i),
    .r_o (residue)
  );

  // next state
  always_comb begin
    acc_en = 1'b1;
    if (load_ok_i) base = fdm_pkg::resync_on(resync_i) ? '0 : residue;
    else           base = acc_q;
    sum   = SUM_W'(base) + SUM_W'(eff_frac_i);
    carry = (sum >= SUM_W'(eff_mod_i));
    acc_d = carry ? MOD_W'(sum - SUM_W'(eff_mod_i)) : MOD_W'(sum);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign carry_o = carry;

  // R1: accumulator never reaches the stored modulus
  assert_acc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < mod_q_i);

  // R4: a resync load restarts from zero, so after one step it holds the numerator
  assert_resync_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok_i && fdm_pkg::resync_on(resync_i)) |=> (acc_q == $past(eff_frac_i)));
endmodule

// File: rtl/fracn_divmod.sv
module fracn_divmod #(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [INT_W-1:0]   int_i,
  input  logic [MOD_W-1:0]   frac_i,
  input  logic [MOD_W-1:0]   mod_i,
  input  logic [3:0]         resync_i,
  output logic [INT_W:0]     div_o,
  output logic               err_o
);
  localparam int DIV_W = INT_W + 1;

  logic             rst_sync_n;
  logic             load_ok;
  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q;
  logic [MOD_W-1:0] mod_q;
  logic [INT_W-1:0] eff_int;
  logic [MOD_W-1:0] eff_frac;
  logic [MOD_W-1:0] eff_mod;
  logic             carry;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             div_en;

  fdm_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fdm_cfg #(.INT_W(INT_W), .MOD_W(MOD_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load_i),
    .int_i      (int_i),
    .frac_i     (frac_i),
    .mod_i      (mod_i),
    .load_ok_o  (load_ok),
    .int_q_o    (int_q),
    .frac_q_o   (frac_q),
    .mod_q_o    (mod_q),
    .eff_int_o  (eff_int),
    .eff_frac_o (eff_frac),
    .eff_mod_o  (eff_mod),
    .err_o      (err_o)
  );

  fdm_accum #(.MOD_W(MOD_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_ok_i  (load_ok),
    .resync_i   (resync_i),
    .eff_frac_i (eff_frac),
    .eff_mod_i  (eff_mod),
    .mod_q_i    (mod_q),
    .carry_o    (carry)
  );

  // next state
  always_comb begin
    div_en = 1'b1;
    div_d  = DIV_W'(eff_int) + DIV_W'(carry);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  assign div_o = div_q;

  // R1: without a load the output is the stored integer part or one above it
  assert_dither_range_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_i |=> ((div_o == DIV_W'($past(int_q))) || (div_o == DIV_W'($past(int_q)) + 1'b1)));

  // R2: an accepted load is reflected on the very next output
  assert_load_apply_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && (frac_i < mod_i)) |=>
      ((div_o == DIV_W'($past(int_i))) || (div_o == DIV_W'($past(int_i)) + 1'b1)));

  // R6: zero numerator means no dithering
  assert_no_dither_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && (frac_q == '0)) |=> (div_o == DIV_W'($past(int_q))));
endmodule

// File: tb/sim_fracn_divmod.sv
`timescale 1ns/1ps
module sim_fracn_divmod;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [15:0] int_i;
  logic [11:0] frac_i;
  logic [11:0] mod_i;
  logic [3:0]  resync_i;
  logic [16:0] div_o;
  logic        err_o;

  fracn_divmod u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .int_i(int_i),
    .frac_i(frac_i), .mod_i(mod_i), .resync_i(resync_i),
    .div_o(div_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    dv;
    bit    er;
    string tag;
  } exp_t;

  exp_t q[$];
  int   hist[$];
  int   vectors = 0;
  int   fails   = 0;
  int   pushed  = 0;

  int m_int, m_frac, m_mod, m_acc;
  bit m_err;

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  task automatic step(input bit ld, input int iv, input int fv, input int mv,
                      input bit [3:0] rs, input string tag);
    int s;
    exp_t e;
    @(negedge clk);
    load_i   = ld;
    int_i    = 16'(iv);
    frac_i   = 12'(fv);
    mod_i    = 12'(mv);
    resync_i = rs;
    if (ld) begin
      if (fv >= mv) m_err = 1'b1;
      else begin
        m_acc  = (rs != 0) ? 0 : (m_acc % mv);
        m_int  = iv; m_frac = fv; m_mod = mv;
        m_err  = 1'b0;
      end
    end
    s = m_acc + m_frac;
    e.dv = m_int;
    if (s >= m_mod) begin
      s = s - m_mod;
      e.dv = m_int + 1;
    end
    m_acc = s;
    e.er  = m_err;
    e.tag = tag;
    q.push_back(e);
    pushed++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 4'h0, tag);
  endtask

  task automatic drain;
    while (q.size() > 0) begin
      @(posedge clk);
      #2;
    end
  endtask

  function automatic longint wsum(input int from, input int n);
    longint t = 0;
    for (int i = 0; i < n; i++) t += hist[from + i];
    return t;
  endfunction

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        hist.push_back(int'(div_o));
        vectors++;
        if (div_o !== 17'(e.dv) || err_o !== e.er) begin
          fails++;
          $display("FAIL %s: div=%0d err=%0b expected div=%0d err=%0b",
                   e.tag, div_o, err_o, e.dv, e.er);
        end
      end
    end
  end

  task automatic run_tests;
    int ia, ia2, ib, same;
    load_i = 0; int_i = 0; frac_i = 0; mod_i = 0; resync_i = 0;
    m_int = 0; m_frac = 0; m_mod = 1; m_acc = 0; m_err = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(div_o == 0, "R9 div during reset", int'(div_o), 0);
    check(err_o == 0, "R9 err during reset", int'(err_o), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    idle(3, "R9 idle after reset");

    // A / B / A with resync
    ia = pushed;
    step(1'b1, 138, 30, 65, 4'h1, "R2 load A");
    idle(129, "R1 A dither");
    step(1'b1, 200, 7, 520, 4'h8, "R2 load B");
    idle(100, "R1 B dither");
    ia2 = pushed;
    step(1'b1, 138, 30, 65, 4'h3, "R4 reload A");
    idle(64, "R4 A replay");
    drain();
    check(wsum(ia, 65) == 9000, "R7 window sum A", int'(wsum(ia, 65)), 9000);
    check(wsum(ia + 65, 65) == 9000, "R7 second period A", int'(wsum(ia + 65, 65)), 9000);
    same = 1;
    for (int k = 0; k < 65; k++) if (hist[ia + k] != hist[ia2 + k]) same = 0;
    check(same == 1, "R4 A/B/A identical sequence", same, 1);

    // residue kept without resync
    step(1'b1, 50, 100, 1000, 4'h0, "R5 load wide");
    idle(13, "R5 run wide");
    step(1'b1, 51, 3, 7, 4'h0, "R5 reload narrow keeps residue");
    idle(20, "R5 run narrow");

    // refused loads
    step(1'b1, 9, 7, 7, 4'h1, "R3 reject frac==mod");
    idle(10, "R3 old setting kept");
    step(1'b1, 9, 10, 0, 4'h0, "R3 reject mod zero");
    idle(5, "R3 flag held");
    step(1'b1, 60, 2, 5, 4'h0, "R3 legal load clears flag");
    idle(5, "R3 after clear");

    // zero numerator
    ib = pushed;
    step(1'b1, 77, 0, 13, 4'h0, "R6 load frac zero");
    idle(25, "R6 constant");
    drain();
    same = 1;
    for (int k = 0; k < 26; k++) if (hist[ib + k] != 77) same = 0;
    check(same == 1, "R6 no dithering", same, 1);

    // loads landing on wrap and non-wrap cycles
    for (int r = 0; r < 12; r++) begin
      step(1'b1, 300 + r, (r % 3) + 1, 3 + 2 * (r % 3), 4'(r % 2), "R2 back-to-back load");
      if (r % 4 == 3) step(1'b1, 1, 9, 9, 4'h2, "R3 reject mid dither");
      idle(r % 3, "R2 between loads");
    end
    step(1'b1, 40, 1, 3, 4'hF, "R2 load then immediate load");
    step(1'b1, 41, 2, 3, 4'h0, "R5 load on next edge");
    idle(6, "R5 settle");

    // full 12-bit modulus
    ib = pushed;
    step(1'b1, 1000, 4094, 4095, 4'h2, "R8 load max modulus");
    idle(4094, "R8 dither");
    step(1'b1, 1, 1, 4093, 4'h4, "R8 odd modulus");
    idle(20, "R8 run");
    drain();
    check(wsum(ib, 4095) == 64'd1000 * 4095 + 4094, "R8 R7 window sum max modulus",
          int'(wsum(ib, 4095)), 1000 * 4095 + 4094);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule